// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block watches up to 95 general-purpose input pins and turns activity on them into a single interrupt request. Each pin arrives already synchronized and already gated by its input-sensing enable. Alongside its level come two configuration bits: a trigger-select bit and an invert bit. Together they pick one of four trigger kinds for that pin: rising edge, falling edge, level-low or level-high. When a pin's trigger fires, the block sets that pin's bit in a status bitmap.

Software reads and clears the status bitmap through a small 32-bit register port. A clear is done by writing 1 to the bits to be cleared. A separate enable bitmap selects which status bits may raise the combined interrupt. Each bitmap is split into 32-bit words, one word per group of 32 pins.

The usual service sequence clears a status bit before handling its pin. An edge that arrives in the same cycle as the clear, or any cycle after it, is therefore captured again and is never lost.

Top module: `gpio_irq_agg`

## Requirements
- R1: A pin with trigger-select 0 and invert 0 sets its status bit on a 0-to-1 change of its level.
- R2: A pin with trigger-select 0 and invert 1 sets its status bit on a 1-to-0 change of its level.
- R3: A pin with trigger-select 1 and invert 0 sets its status bit on every cycle its level is 0. A clear made while the level is still 0 is undone on the next cycle.
- R4: A pin with trigger-select 1 and invert 1 sets its status bit on every cycle its level is 1.
- R5: Pin p maps to bit p mod 32 of word p/32. The status word k is read and written at byte address 0x80+4k, and the enable word k at 0x90+4k. Bits for pins that do not exist read 0. Any other address reads 0.
- R6: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When a trigger and a clear of the same status bit fall in one cycle, the bit ends up set.
- R8: `irq_o` is high exactly when some pin has both its status bit and its enable bit set. Status bits are set whether or not the pin is enabled.
- R9: After reset, all status and enable bits read 0, `irq_o` is low, and every pin's previous level is taken as 0.
- R10: An edge is found by comparing a pin's level with its level one cycle earlier. A level that stays constant produces no further events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | 95 | Synchronized, sensing-gated pin levels |
| trig_sel_i | input | 95 | Per-pin trigger select: 0 edge, 1 level |
| trig_inv_i | input | 95 | Per-pin polarity invert |
| reg_addr_i | input | 8 | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe, one word per cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
A pin trigger and a software clear of the same status bit can land on one clock edge. The bench provokes this on every table vector by changing the pin level in the same cycle as the write of 1s to that pin's status word. The status bit read one cycle later must then equal the trigger outcome alone: set for an edge in the configured direction or for an active level, and clear otherwise. A held active level is also cleared in a later cycle, and the bench checks that the bit comes back on the following read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned WORD_W = 32;

  // {trigger-select, invert}
  typedef enum logic [1:0] {
    TRIG_RISE   = 2'b00,
    TRIG_FALL   = 2'b01,
    TRIG_LVL_LO = 2'b10,
    TRIG_LVL_HI = 2'b11
  } trig_mode_e;

  function automatic int unsigned words_for(input int unsigned n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 95
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] trig_sel_i,
  input  logic [N_PINS-1:0] trig_inv_i,
  output logic [N_PINS-1:0] evt_o
);
  logic [N_PINS-1:0] prev_q;
  logic              past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      prev_q    <= lvl_i;
      past_ok_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    trig_mode_e mode;
    assign mode = trig_mode_e'({trig_sel_i[p], trig_inv_i[p]});
    always_comb begin
      unique case (mode)
        TRIG_RISE:   evt_o[p] = lvl_i[p] & ~prev_q[p];
        TRIG_FALL:   evt_o[p] = ~lvl_i[p] & prev_q[p];
        TRIG_LVL_LO: evt_o[p] = ~lvl_i[p];
        TRIG_LVL_HI: evt_o[p] = lvl_i[p];
        default:     evt_o[p] = 1'b0;
      endcase
    end
  end

  // an edge-mode event needs a level change since last cycle
  assert_edge_needs_change_R10: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !past_ok_q)
    ((evt_o & ~trig_sel_i & ~(lvl_i ^ $past(lvl_i))) == '0));
endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word
  import gpio_irq_pkg::*;
#(
  parameter int unsigned VALID_BITS = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] evt_i,
  input  logic [WORD_W-1:0] clr_i,
  input  logic              en_wr_i,
  input  logic [WORD_W-1:0] en_wdata_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] en_o,
  output logic              pend_o
);
  localparam logic [WORD_W-1:0] VMASK = WORD_W'((64'd1 << VALID_BITS) - 64'd1);

  logic [WORD_W-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      // set dominates clear
      stat_q <= ((stat_q & ~clr_i) | evt_i) & VMASK;
      if (en_wr_i) en_q <= en_wdata_i & VMASK;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

  assert_w1c_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((stat_o & $past(clr_i & ~evt_i & VMASK)) == '0));

  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & VMASK)) |=> ((stat_o & $past(evt_i & VMASK)) == $past(evt_i & VMASK)));
endmodule

// File: rtl/gpio_irq_regif.sv
module gpio_irq_regif
  import gpio_irq_pkg::*;
#(
  parameter int unsigned        N_WORDS   = 3,
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  STAT_BASE = 'h80,
  parameter logic [ADDR_W-1:0]  EN_BASE   = 'h90
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0] stat_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0] en_i,
  output logic [N_WORDS-1:0][WORD_W-1:0] clr_o,
  output logic [N_WORDS-1:0]             en_wr_o,
  output logic [WORD_W-1:0]              rdata_o
);
  logic [N_WORDS-1:0] stat_hit, en_hit;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_dec
    assign stat_hit[k] = (addr_i == STAT_BASE + ADDR_W'(4 * k));
    assign en_hit[k]   = (addr_i == EN_BASE + ADDR_W'(4 * k));
    assign clr_o[k]    = (wr_i && stat_hit[k]) ? wdata_i : '0;
    assign en_wr_o[k]  = wr_i && en_hit[k];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (stat_hit[k]) rdata_o = rdata_o | stat_i[k];
      if (en_hit[k])   rdata_o = rdata_o | en_i[k];
    end
  end

  // one access targets at most one word
  always_comb begin
    assert_single_word_R5: assert ($onehot0({stat_hit, en_hit}));
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned       N_PINS    = 95,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h80,
  parameter logic [ADDR_W-1:0] EN_BASE   = 'h90
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_lvl_i,
  input  logic [N_PINS-1:0] trig_sel_i,
  input  logic [N_PINS-1:0] trig_inv_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned N_WORDS = words_for(N_PINS);
  localparam int unsigned PAD_W   = N_WORDS * WORD_W;

  logic [N_PINS-1:0]              evt;
  logic [PAD_W-1:0]               evt_pad, stat_flat, lvl_act;
  logic [N_WORDS-1:0][WORD_W-1:0] stat_w, en_w, clr_w;
  logic [N_WORDS-1:0]             en_wr, pend_w;

  gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (pin_lvl_i),
    .trig_sel_i (trig_sel_i),
    .trig_inv_i (trig_inv_i),
    .evt_o      (evt)
  );

  assign evt_pad = PAD_W'(evt);

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    localparam int unsigned VB =
      ((N_PINS - k * WORD_W) >= WORD_W) ? WORD_W : (N_PINS - k * WORD_W);
    gpio_irq_word #(.VALID_BITS(VB)) u_word (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_pad[k*WORD_W +: WORD_W]),
      .clr_i      (clr_w[k]),
      .en_wr_i    (en_wr[k]),
      .en_wdata_i (reg_wdata_i),
      .stat_o     (stat_w[k]),
      .en_o       (en_w[k]),
      .pend_o     (pend_w[k])
    );
    assign stat_flat[k*WORD_W +: WORD_W] = stat_w[k];
  end

  gpio_irq_regif #(
    .N_WORDS   (N_WORDS),
    .ADDR_W    (ADDR_W),
    .STAT_BASE (STAT_BASE),
    .EN_BASE   (EN_BASE)
  ) u_regif (
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat_w),
    .en_i    (en_w),
    .clr_o   (clr_w),
    .en_wr_o (en_wr),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o = |pend_w;

  // active level per pin in level mode
  assign lvl_act = PAD_W'(trig_sel_i & ~(pin_lvl_i ^ trig_inv_i));

  assert_level_sets_R3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_act) |=> ((stat_flat & $past(lvl_act)) == $past(lvl_act)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|en_w) && (|stat_flat)));

  assert_reset_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/sim_gpio_irq_agg.sv
module sim_gpio_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 95;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] lvl = '0, tsel = '0, tinv = '0;
  logic [7:0]    addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(lvl), .trig_sel_i(tsel),
    .trig_inv_i(tinv), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {pin[6:0], trig_sel, invert, level_before, level_after, expected_status}
  localparam logic [11:0] VEC [12] = '{
    {7'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R1 rise
    {7'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 no rise
    {7'd40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 fall
    {7'd40, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 no fall
    {7'd70, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 low
    {7'd70, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 leaves low
    {7'd94, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 high
    {7'd94, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 leaves high
    {7'd31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R1 word boundary
    {7'd32, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 word boundary
    {7'd63, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // R4 held through clear
    {7'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}   // R10 held, no edge
  };

  function automatic string req_of(input logic ts, input logic ti, input logic b, input logic a);
    if (!ts && b == a) return "R10";
    case ({ts, ti})
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a negedge, returns at the next negedge
  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int k = 0; k < 3; k++) begin
      reg_read(8'h80 + 8'(4 * k), rd); chk("R9 status", rd, 32'h0);
      reg_read(8'h90 + 8'(4 * k), rd); chk("R9 enable", rd, 32'h0);
    end
    chk("R9 irq", 32'(irq), 32'h0);

    // R8 status latches while disabled
    @(negedge clk); lvl[3] = 1'b1;
    @(negedge clk);
    reg_read(8'h80, rd); chk("R8 status without enable", rd, 32'h8);
    chk("R8 irq masked", 32'(irq), 32'h0);
    reg_write(8'h90, 32'h8);
    chk("R8 irq enabled", 32'(irq), 32'h1);

    // R6 write 0 keeps, write 1 clears
    reg_write(8'h80, 32'h0);
    reg_read(8'h80, rd); chk("R6 zero write", rd, 32'h8);
    reg_write(8'h80, 32'h8);
    reg_read(8'h80, rd); chk("R6 one write", rd, 32'h0);
    chk("R6 irq drop", 32'(irq), 32'h0);
    repeat (3) @(negedge clk);
    reg_read(8'h80, rd); chk("R10 held level no re-edge", rd, 32'h0);
    lvl[3] = 1'b0;

    // R3 clear while level still active
    tsel[10] = 1'b1;
    @(negedge clk);
    reg_write(8'h80, 32'h400);
    @(negedge clk);
    reg_read(8'h80, rd); chk("R3 level re-sets", rd, 32'h400);
    tsel[10] = 1'b0;
    @(negedge clk);
    reg_write(8'h80, 32'hFFFF_FFFF);
    reg_read(8'h80, rd); chk("R3 cleared after level mode off", rd, 32'h0);

    // R5 unused bit and unmapped address
    reg_write(8'h98, 32'hFFFF_FFFF);
    reg_read(8'h98, rd); chk("R5 top word enable", rd, 32'h7FFF_FFFF);
    reg_read(8'h40, rd); chk("R5 unmapped read", rd, 32'h0);
    reg_write(8'h90, 32'hFFFF_FFFF);
    reg_write(8'h94, 32'hFFFF_FFFF);

    // table: level change lands in the same cycle as the clear (R7)
    for (int i = 0; i < 12; i++) begin
      logic [6:0]  pin;
      logic [7:0]  sa;
      logic [31:0] mask;
      string       tag;
      pin  = VEC[i][11:5];
      sa   = 8'h80 + 8'(4 * (pin / 32));
      mask = 32'h1 << (pin % 32);
      tag  = req_of(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      lvl = '0; tsel = '0; tinv = '0;
      tsel[pin] = VEC[i][4];
      tinv[pin] = VEC[i][3];
      lvl[pin]  = VEC[i][2];
      @(posedge clk); @(posedge clk); @(negedge clk);
      for (int k = 0; k < 3; k++) reg_write(8'h80 + 8'(4 * k), 32'hFFFF_FFFF);
      lvl[pin] = VEC[i][1];
      reg_write(sa, 32'hFFFF_FFFF);
      reg_read(sa, rd);
      chk({tag, " R7 status"}, rd & mask, VEC[i][0] ? mask : 32'h0);
      chk({tag, " R8 irq"}, 32'(irq), 32'(VEC[i][0]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule